// File: doc/BRIEF.md
# UART FIFO Ready and Interrupt Signaling

This block models one channel of a dual UART at the level of its buffers and status pins. It holds a receive FIFO and a transmit FIFO, each with a level counter. From their occupancy it drives two active-low ready pins and an active-high interrupt level. The host side pushes received bytes into the receive FIFO and pops them out. It also pushes bytes for transmission into the transmit FIFO, and the transmitter pops them out. Serial shifting, baud timing and register decoding sit outside the block. The transmitter reports only whether its shift register is empty.

Three operating modes change what the ready pins mean. With the FIFOs off, each direction behaves as a single holding register. With the FIFOs on and block transfer off, the pins follow empty and non-empty. With block transfer on, the receive pin latches low once the trigger level or a receive timeout is reached and stays low until the FIFO drains. In that mode the transmit pin signals "full". The interrupt combines a receive condition, which is a level against the receive trigger, and a transmit condition, which is "below trigger or empty". When automatic RS-485 direction control is on, "empty" for the transmitter means both the FIFO and the shift register are empty.

Top module: `uart_fifo_sig`

## Requirements
- R1: While reset is asserted, both levels read 0, rxRdyN is 1, txRdyN is 0 and intOut is 0, and both FIFOs are emptied.
- R2: Each FIFO stores up to DEPTH (64) bytes in first-in first-out order. Its level port shows the current occupancy one clock after a push or pop edge. Pop data appears on the pop data port one clock after the pop strobe.
- R3: A push into a full FIFO is ignored. A pop from an empty FIFO leaves the level unchanged and returns 0. A push and a pop in the same clock on a non-empty FIFO leave the level unchanged.
- R4: With fifoEn=0, each FIFO holds at most one byte. rxRdyN is 0 exactly when a received byte is held, and txRdyN is 1 exactly when a transmit byte is held.
- R5: With fifoEn=1 and blockMode=0, rxRdyN is 0 exactly when the receive level is at least 1, and txRdyN is 0 exactly when the transmit level is 0.
- R6: With fifoEn=1 and blockMode=1, rxRdyN goes low when the receive level is at or above rxTrig, or when rxTimeout pulses while the level is non-zero. It then stays low until the receive level is 0.
- R7: With fifoEn=1 and blockMode=1, txRdyN is 1 exactly when the transmit level equals DEPTH.
- R8: The receive interrupt condition is "level non-zero" with FIFOs off. With FIFOs on it is "level non-zero and at or above rxTrig", where rxTrig ranges from 1 to 64.
- R9: The transmit "empty" condition is a transmit level of 0. When autoRs485=1, txShiftEmpty=1 is also required. The transmit interrupt condition is "empty" with FIFOs off. With FIFOs on it is "empty, or level non-zero and below txTrig".
- R10: intOut is the OR of the two interrupt conditions. intOut and both ready pins are registered and reflect the levels and inputs present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | 1 enables the FIFOs, 0 makes each a holding register |
| blockMode | input | 1 | 1 selects block-transfer pin behaviour |
| rxTrig | input | CNT_W | Receive trigger level (1 to DEPTH) |
| txTrig | input | CNT_W | Transmit trigger level (1 to DEPTH) |
| autoRs485 | input | 1 | Transmit empty also requires an empty shift register |
| rxTimeout | input | 1 | Receive timeout strobe |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rxPush | input | 1 | Push a received byte |
| rxPushData | input | DATA_W | Received byte |
| rxPop | input | 1 | Pop a byte from the receive FIFO |
| rxPopData | output | DATA_W | Byte popped from the receive FIFO |
| txPush | input | 1 | Push a byte to transmit |
| txPushData | input | DATA_W | Byte to transmit |
| txPop | input | 1 | Transmitter takes a byte |
| txPopData | output | DATA_W | Byte popped from the transmit FIFO |
| rxLevel | output | CNT_W | Receive FIFO occupancy |
| txLevel | output | CNT_W | Transmit FIFO occupancy |
| rxRdyN | output | 1 | Active-low receive ready pin |
| txRdyN | output | 1 | Active-low transmit ready pin |
| intOut | output | 1 | Active-high interrupt level |

## Verification
The receive FIFO is first filled and drained partly below the trigger level. This separates the single-character pin, which tracks "non-empty", from the block-mode pin, which waits for the trigger. Draining to one remaining byte in block mode tests that the latch holds rather than following the level. A timeout pulse below the trigger tests the second set source. The transmit FIFO is filled to exactly 64 entries and then popped once, which shows the full boundary of the block-mode pin. Toggling the shift-empty flag with an empty FIFO shows whether the RS-485 option changes the transmit interrupt. Overfilling, popping past empty and a combined push and pop while full separate the acceptance rules. Scoreboard comparison of the popped bytes confirms ordering and the zero returned on an empty pop.

// File: rtl/uart_sig_pkg.sv
package uart_sig_pkg;
  // Accepted-operation strobes from control to datapath
  typedef struct packed {
    logic rxWr;
    logic rxRd;
    logic rxRdMiss;
    logic txWr;
    logic txRd;
    logic txRdMiss;
  } fifoStrb_t;
endpackage

// File: rtl/uart_sig_fifo.sv
module uart_sig_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wr,
  input  logic              rd,
  input  logic              rdMiss,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (wr) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (rd) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (rd)          rdData <= mem[rdPtr];
      else if (rdMiss) rdData <= '0;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rd |-> count != '0); // R3
  AST_PAIR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wr && rd) |=> count == $past(count)); // R3
endmodule

// File: rtl/uart_sig_dp.sv
module uart_sig_dp
  import uart_sig_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic [DATA_W-1:0] txPushData,
  output logic [DATA_W-1:0] rxPopData,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  rxCount,
  output logic [CNT_W-1:0]  txCount
);
  uart_sig_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .wr(strb.rxWr), .rd(strb.rxRd),
    .rdMiss(strb.rxRdMiss), .wrData(rxPushData), .rdData(rxPopData),
    .count(rxCount));

  uart_sig_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .wr(strb.txWr), .rd(strb.txRd),
    .rdMiss(strb.txRdMiss), .wrData(txPushData), .rdData(txPopData),
    .count(txCount));
endmodule

// File: rtl/uart_sig_ctrl.sv
module uart_sig_ctrl
  import uart_sig_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             blockMode,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic [CNT_W-1:0] txTrig,
  input  logic             autoRs485,
  input  logic             rxTimeout,
  input  logic             txShiftEmpty,
  input  logic             rxPushReq,
  input  logic             rxPopReq,
  input  logic             txPushReq,
  input  logic             txPopReq,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] txCount,
  output fifoStrb_t        strb,
  output logic             rxRdyN,
  output logic             txRdyN,
  output logic             intOut
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] capacity;
  logic blockOn, rxLatch, rxLatchNxt;
  logic rxIntC, txEmptyC, txIntC;

  // Acceptance: a push into a full FIFO passes only alongside a real pop
  always_comb begin
    capacity      = fifoEn ? FULL : ONE;
    strb.rxRd     = rxPopReq && (rxCount != '0);
    strb.rxRdMiss = rxPopReq && (rxCount == '0);
    strb.rxWr     = rxPushReq && ((rxCount < capacity) || strb.rxRd);
    strb.txRd     = txPopReq && (txCount != '0);
    strb.txRdMiss = txPopReq && (txCount == '0);
    strb.txWr     = txPushReq && ((txCount < capacity) || strb.txRd);
  end

  // Block-mode receive latch: clear on empty wins over set
  always_comb begin
    blockOn = fifoEn && blockMode;
    if (!blockOn || rxCount == '0)                  rxLatchNxt = 1'b0;
    else if ((rxCount >= rxTrig) || rxTimeout)      rxLatchNxt = 1'b1;
    else                                            rxLatchNxt = rxLatch;
  end

  always_comb begin
    rxIntC   = fifoEn ? ((rxCount != '0) && (rxCount >= rxTrig)) : (rxCount != '0);
    txEmptyC = (txCount == '0) && (!autoRs485 || txShiftEmpty);
    txIntC   = fifoEn ? (((txCount != '0) && (txCount < txTrig)) || txEmptyC) : txEmptyC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLatch <= 1'b0;
      rxRdyN  <= 1'b1;
      txRdyN  <= 1'b0;
      intOut  <= 1'b0;
    end else begin
      rxLatch <= rxLatchNxt;
      rxRdyN  <= blockOn ? !rxLatchNxt : (rxCount == '0);
      txRdyN  <= blockOn ? (txCount == FULL) : (txCount != '0);
      intOut  <= rxIntC || txIntC;
    end
  end

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && blockMode && $past(fifoEn && blockMode) && !rxRdyN && rxCount != '0)
    |=> !rxRdyN); // R6
  AST_TX_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && blockMode && txCount == FULL) |=> txRdyN); // R7
  AST_SINGLE_RX_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && !blockMode && rxCount == '0) |=> rxRdyN); // R5
  AST_RX_INT: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && rxCount != '0 && rxCount >= rxTrig) |=> intOut); // R8
  AST_OFF_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && rxCount != '0 && !rxPopReq) |-> !strb.rxWr); // R4
endmodule

// File: rtl/uart_fifo_sig.sv
module uart_fifo_sig
  import uart_sig_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              blockMode,
  input  logic [CNT_W-1:0]  rxTrig,
  input  logic [CNT_W-1:0]  txTrig,
  input  logic              autoRs485,
  input  logic              rxTimeout,
  input  logic              txShiftEmpty,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  rxLevel,
  output logic [CNT_W-1:0]  txLevel,
  output logic              rxRdyN,
  output logic              txRdyN,
  output logic              intOut
);
  fifoStrb_t strb;

  uart_sig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .blockMode(blockMode),
    .rxTrig(rxTrig), .txTrig(txTrig), .autoRs485(autoRs485),
    .rxTimeout(rxTimeout), .txShiftEmpty(txShiftEmpty),
    .rxPushReq(rxPush), .rxPopReq(rxPop), .txPushReq(txPush), .txPopReq(txPop),
    .rxCount(rxLevel), .txCount(txLevel), .strb(strb),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN), .intOut(intOut));

  uart_sig_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxPushData(rxPushData), .txPushData(txPushData),
    .rxPopData(rxPopData), .txPopData(txPopData),
    .rxCount(rxLevel), .txCount(txLevel));
endmodule

// File: tb/uart_fifo_sig_bench.sv
`timescale 1ns/1ps
module uart_fifo_sig_bench;
  localparam int DEPTH = 64;
  localparam int DATA_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEn = 1'b1, blockMode = 1'b0, autoRs485 = 1'b0;
  logic rxTimeout = 1'b0, txShiftEmpty = 1'b1;
  logic [CNT_W-1:0] rxTrig = 7'd4, txTrig = 7'd8;
  logic rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic [DATA_W-1:0] rxPushData = '0, txPushData = '0;
  logic [DATA_W-1:0] rxPopData, txPopData;
  logic [CNT_W-1:0] rxLevel, txLevel;
  logic rxRdyN, txRdyN, intOut;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uart_fifo_sig u_uart_fifo_sig (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .blockMode(blockMode),
    .rxTrig(rxTrig), .txTrig(txTrig), .autoRs485(autoRs485),
    .rxTimeout(rxTimeout), .txShiftEmpty(txShiftEmpty),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .rxLevel(rxLevel), .txLevel(txLevel), .rxRdyN(rxRdyN), .txRdyN(txRdyN),
    .intOut(intOut));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- Scoreboard / reference model ----------------
  int rxQ[$], txQ[$];
  bit valid = 0, mLatch = 0, rxPend = 0, txPend = 0;
  int expRxData, expTxData, rxN, txN, cap;
  bit expRxRdyN, expTxRdyN, expInt, rxIntM, txIntM, txEmptyM, rOk, tOk, nLatch;
  string rxTag, txTag;

  always @(posedge clk) begin
    if (!rstN) begin
      rxQ.delete(); txQ.delete();
      valid = 0; mLatch = 0; rxPend = 0; txPend = 0;
    end else begin
      rxN = rxQ.size(); txN = txQ.size();
      cap = fifoEn ? DEPTH : 1;
      if (fifoEn && blockMode) begin
        if (rxN == 0) nLatch = 0;
        else if (rxN >= int'(rxTrig) || rxTimeout) nLatch = 1;
        else nLatch = mLatch;
        expRxRdyN = !nLatch;
        expTxRdyN = (txN == DEPTH);
        rxTag = "R6"; txTag = "R7";
      end else begin
        nLatch = 0;
        expRxRdyN = (rxN == 0);
        expTxRdyN = (txN != 0);
        rxTag = fifoEn ? "R5" : "R4"; txTag = rxTag;
      end
      mLatch = nLatch;
      rxIntM = fifoEn ? (rxN != 0 && rxN >= int'(rxTrig)) : (rxN != 0);
      txEmptyM = (txN == 0) && (!autoRs485 || txShiftEmpty);
      txIntM = fifoEn ? ((txN != 0 && txN < int'(txTrig)) || txEmptyM) : txEmptyM;
      expInt = rxIntM || txIntM;
      // receive FIFO
      rOk = rxPop && rxN > 0;
      rxPend = rxPop;
      if (rOk) expRxData = rxQ.pop_front(); else if (rxPop) expRxData = 0;
      if (rxPush && (rxN < cap || rOk)) rxQ.push_back(int'(rxPushData));
      // transmit FIFO
      tOk = txPop && txN > 0;
      txPend = txPop;
      if (tOk) expTxData = txQ.pop_front(); else if (txPop) expTxData = 0;
      if (txPush && (txN < cap || tOk)) txQ.push_back(int'(txPushData));
      valid = 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && valid) begin
      chk(rxTag, "rxRdyN", int'(rxRdyN), int'(expRxRdyN));
      chk(txTag, "txRdyN", int'(txRdyN), int'(expTxRdyN));
      chk("R10", "intOut", int'(intOut), int'(expInt));          // R8 R9 folded in
      chk("R2", "rxLevel", int'(rxLevel), rxQ.size());
      chk("R2", "txLevel", int'(txLevel), txQ.size());
      if (rxPend) chk("R2", "rxPopData", int'(rxPopData), expRxData); // R3 zero on miss
      if (txPend) chk("R2", "txPopData", int'(txPopData), expTxData);
    end
  end

  // ---------------- Driver tasks (start and end at a negedge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushRx(input int d);
    rxPush = 1'b1; rxPushData = DATA_W'(d);
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1; @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic pushTx(input int d);
    txPush = 1'b1; txPushData = DATA_W'(d);
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1; @(negedge clk); txPop = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1", "rxRdyN", int'(rxRdyN), 1);
    chk("R1", "txRdyN", int'(txRdyN), 0);
    chk("R1", "intOut", int'(intOut), 0);
    chk("R1", "rxLevel", int'(rxLevel), 0);
    chk("R1", "txLevel", int'(txLevel), 0);
    rstN = 1'b1;
    idle(2);

    // Single-character mode: R5, R2
    for (int i = 0; i < 3; i++) pushRx(8'hA0 + i);
    idle(1);
    chk("R2", "rxLevel after 3 pushes", int'(rxLevel), 3);
    chk("R5", "rxRdyN non-empty", int'(rxRdyN), 0);
    for (int i = 0; i < 3; i++) popRx();
    idle(1);
    chk("R5", "rxRdyN drained", int'(rxRdyN), 1);
    pushTx(8'h11); pushTx(8'h22);
    idle(1);
    chk("R5", "txRdyN holding data", int'(txRdyN), 1);
    chk("R9", "intOut tx below trigger", int'(intOut), 1);
    popTx(); popTx(); idle(1);

    // Overflow, underflow, simultaneous: R3
    for (int i = 0; i < DEPTH + 2; i++) pushRx(i);
    idle(1);
    chk("R3", "rxLevel after overfill", int'(rxLevel), DEPTH);
    rxPush = 1'b1; rxPushData = 8'hEE; rxPop = 1'b1;
    @(negedge clk); rxPush = 1'b0; rxPop = 1'b0;
    idle(1);
    chk("R3", "rxLevel after push+pop full", int'(rxLevel), DEPTH);
    for (int i = 0; i < DEPTH + 2; i++) popRx();
    idle(1);
    chk("R3", "rxLevel after over-pop", int'(rxLevel), 0);
    chk("R3", "rxPopData on empty pop", int'(rxPopData), 0);

    // Block mode receive: R6
    blockMode = 1'b1; rxTrig = 7'd8; idle(2);
    for (int i = 0; i < 5; i++) pushRx(8'h30 + i);
    idle(1);
    chk("R6", "rxRdyN below trigger", int'(rxRdyN), 1);
    for (int i = 0; i < 3; i++) pushRx(8'h40 + i);
    idle(1);
    chk("R6", "rxRdyN at trigger", int'(rxRdyN), 0);
    for (int i = 0; i < 7; i++) popRx();
    idle(1);
    chk("R6", "rxRdyN held with 1 byte", int'(rxRdyN), 0);
    popRx(); idle(1);
    chk("R6", "rxRdyN released on empty", int'(rxRdyN), 1);
    pushRx(8'h55); pushRx(8'h66); idle(1);
    chk("R6", "rxRdyN 2 bytes no timeout", int'(rxRdyN), 1);
    rxTimeout = 1'b1; @(negedge clk); rxTimeout = 1'b0;
    idle(1);
    chk("R6", "rxRdyN after timeout", int'(rxRdyN), 0);
    popRx(); popRx(); idle(1);

    // Block mode transmit: R7
    for (int i = 0; i < DEPTH; i++) pushTx(i ^ 8'h5A);
    idle(1);
    chk("R7", "txRdyN full", int'(txRdyN), 1);
    popTx(); idle(1);
    chk("R7", "txRdyN one free", int'(txRdyN), 0);
    for (int i = 0; i < DEPTH - 1; i++) popTx();
    idle(1);

    // RS-485 transmit empty: R9, R10
    blockMode = 1'b0; autoRs485 = 1'b1; txShiftEmpty = 1'b0; rxTrig = 7'd4;
    idle(2);
    chk("R9", "intOut shift busy", int'(intOut), 0);
    txShiftEmpty = 1'b1; idle(2);
    chk("R9", "intOut shift empty", int'(intOut), 1);
    txShiftEmpty = 1'b0;
    for (int i = 0; i < 4; i++) pushRx(8'h70 + i);
    idle(1);
    chk("R10", "intOut from rx only", int'(intOut), 1);
    for (int i = 0; i < 4; i++) popRx();
    idle(1);

    // FIFOs off: R4
    fifoEn = 1'b0; autoRs485 = 1'b0; txShiftEmpty = 1'b1; idle(2);
    pushRx(8'h81); pushRx(8'h82); idle(1);
    chk("R4", "rxLevel holding reg", int'(rxLevel), 1);
    chk("R4", "rxRdyN byte held", int'(rxRdyN), 0);
    chk("R8", "intOut rx held", int'(intOut), 1);
    popRx(); idle(1);
    pushTx(8'h91); idle(1);
    chk("R4", "txRdyN byte held", int'(txRdyN), 1);
    chk("R9", "intOut tx held", int'(intOut), 0);
    popTx(); idle(1);
    chk("R4", "txRdyN empty", int'(txRdyN), 0);
    idle(2);
    finishRun();
  end
endmodule